// File: doc/BRIEF.md
# DMA Command Address Window Router

This block takes one DMA command per valid/ready handshake. A command has an opcode, a tag, a local-store address, a 64-bit effective address and a byte size. The block decides where the command goes. It can become an ordinary put or get against main memory. It can become a transfer into the local store of a peer processing element in the same group. It can become a 32-bit write into one of that peer's two signal registers. Anything it cannot place ends with an error status.

Effective addresses whose bits [31:28] are all ones fall in a group window. Inside that window, the low 28 bits split into two parts. Bits [27:20] give a peer index and bits [19:0] give an offset into that peer's aperture. Routed requests leave through a request port and are held until the data mover takes them. A separate completion pulse retires each request. Commands that carry an ordering modifier wait until every earlier request has been retired.

The block keeps two 32-bit signal registers for each peer. Each register has its own mode bit. The mode bit selects whether an incoming value is ORed into the register or replaces it.

Top module: `dma_win_router`

## Requirements
- R1: Opcode bits [2:0] are modifier bits (bit 0 barrier, bit 1 fence, bit 2 list). They are cleared before the opcode is classified. A base value of 8'h20 is a put and 8'h40 is a get.
- R2: Outside the window, a put is routed with `req_put_o`=1 and a get with `req_put_o`=0, and `req_ea_o` carries the command's effective address. Any other opcode gives an error and no request.
- R3: A command is in the window exactly when effective-address bits [31:28] equal 4'hF. Bits [63:32] play no part in that test.
- R4: A window command issued while `grp_valid_i` is low gives an error.
- R5: A window command whose peer index is N_PEER or more, or whose slot bit in `peer_present_i` is clear, gives an error.
- R6: A window put or get with offset at most 0x3FFFF and offset+size at most 0x40000 is routed to LS_BASE + index*LS_STRIDE + offset, keeping its direction.
- R7: A put of size 4 to offset 0x05400C writes signal register 1 of the peer, and one to offset 0x05C00C writes register 2. The value written is `ls_rd_data_i`, read at `ls_rd_addr_o` = the command's local-store address. The command succeeds without issuing a request.
- R8: Mode bit `snr_mode_i[2p]` governs register 1 of peer p, and bit `[2p+1]` governs register 2. A set bit ORs the new value into the register. A clear bit overwrites the register.
- R9: Every other window command gives an error and no request. This covers non-put/get opcodes in the local-store aperture, gets or sizes other than 4 at a signal offset, and any other offset.
- R10: `sts_valid_o` pulses for exactly one cycle, in the cycle after acceptance. `sts_err_o` is 0 for success and 1 for error.
- R11: A command with the barrier or fence bit is not accepted while any routed request is still waiting for `cpl_i`. A list-only modifier does not hold the command.
- R12: A pending request keeps its fields stable until `req_ready_i`. No command is accepted while a request is pending.
- R13: After reset there is no request and no status, `cmd_ready_o` is high, and all signal registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted this cycle when valid |
| cmd_op_i | input | 8 | Opcode with modifier bits [2:0] |
| cmd_tag_i | input | TAG_W | Command tag |
| cmd_lsa_i | input | LSA_W | Issuer local-store address |
| cmd_ea_i | input | 64 | Effective address |
| cmd_size_i | input | SIZE_W | Transfer size in bytes |
| grp_valid_i | input | 1 | Issuer belongs to a group |
| peer_present_i | input | N_PEER | Occupied peer slots |
| snr_mode_i | input | 2*N_PEER | Per-register OR mode bits |
| ls_rd_addr_o | output | LSA_W | Issuer local-store read address |
| ls_rd_data_i | input | 32 | Word read from issuer local store |
| req_valid_o | output | 1 | Routed request pending |
| req_ready_i | input | 1 | Data mover takes the request |
| req_put_o | output | 1 | 1: local store to address, 0: address to local store |
| req_ea_o | output | 64 | Target address |
| req_lsa_o | output | LSA_W | Issuer local-store address |
| req_size_o | output | SIZE_W | Transfer size |
| req_tag_o | output | TAG_W | Tag |
| cpl_i | input | 1 | One routed request completed |
| sts_valid_o | output | 1 | Status valid |
| sts_err_o | output | 1 | 1 = sequence error |
| snr_rd_peer_i | input | 8 | Signal register read peer |
| snr_rd_sel_i | input | 1 | 0: register 1, 1: register 2 |
| snr_rd_data_o | output | 32 | Signal register value |

## Verification
A table of commands covers several cases, and each tells a different routing decision apart:
- Puts and gets below the window, including addresses with high bits set.
- Modified opcodes.
- Window addresses aimed at valid, absent and out-of-range peers.
- Aperture sizes that end exactly on the 256 KiB limit and one byte past it.
- Signal offsets with the wrong opcode or size.
- An address one nibble short of the window.

Directed sequences then cover the signal-register modes. Two writes of disjoint bit patterns tell OR from overwrite, and per-peer, per-register mode bits tell the two registers and the two peers apart. Further directed sequences cover the missing group, barrier and list behaviour with a request still outstanding, and a request held back by the data mover.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  localparam logic [7:0] OP_MOD_MASK = 8'h07;
  localparam logic [7:0] OP_PUT      = 8'h20;
  localparam logic [7:0] OP_GET      = 8'h40;
  localparam logic [3:0] WIN_NIBBLE  = 4'hF;
  localparam int         OFF_W       = 20;
  localparam int         IDX_W       = 8;
  localparam logic [31:0] LS_LIMIT   = 32'h0004_0000;
  localparam logic [19:0] LS_MAX_OFF = 20'h3FFFF;
  localparam logic [19:0] SNR1_OFF   = 20'h5400C;
  localparam logic [19:0] SNR2_OFF   = 20'h5C00C;

  typedef enum logic [1:0] {
    RT_ERR = 2'd0,
    RT_XFER = 2'd1,
    RT_SNR = 2'd2
  } route_e;
endpackage

// File: rtl/dwr_decode.sv
module dwr_decode
  import dwr_pkg::*;
#(
  parameter int          N_PEER    = 6,
  parameter int          SIZE_W    = 16,
  parameter logic [63:0] LS_BASE   = 64'h0000_0002_0000_0000,
  parameter logic [63:0] LS_STRIDE = 64'h0000_0000_0004_0000
) (
  input  logic [7:0]        op_i,
  input  logic [63:0]       ea_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              grp_i,
  input  logic [N_PEER-1:0] present_i,
  output route_e            route_o,
  output logic              put_o,
  output logic [63:0]       tgt_ea_o,
  output logic [IDX_W-1:0]  peer_o,
  output logic              snr_sel_o
);
  logic [7:0]       op_base;
  logic             is_put, is_get, in_win, peer_ok, ls_fit, snr_hit;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic [31:0]      off_end;

  assign op_base = op_i & ~OP_MOD_MASK;
  assign is_put  = (op_base == OP_PUT);
  assign is_get  = (op_base == OP_GET);
  assign in_win  = (ea_i[31:28] == WIN_NIBBLE);
  assign idx     = ea_i[27:20];
  assign off     = ea_i[19:0];
  assign off_end = 32'(off) + 32'(size_i);
  assign ls_fit  = (off <= LS_MAX_OFF) && (off_end <= LS_LIMIT);
  assign snr_hit = is_put && (size_i == SIZE_W'(4)) && (off == SNR1_OFF || off == SNR2_OFF);

  always_comb begin
    peer_ok = 1'b0;
    for (int p = 0; p < N_PEER; p++) begin
      if (idx == IDX_W'(p) && present_i[p]) peer_ok = 1'b1;
    end
  end

  assign put_o     = is_put;
  assign peer_o    = idx;
  assign snr_sel_o = (off == SNR2_OFF);

  always_comb begin
    route_o  = RT_ERR;
    tgt_ea_o = ea_i;
    if (!in_win) begin
      if (is_put || is_get) route_o = RT_XFER;
    end else if (grp_i && peer_ok) begin
      if (ls_fit) begin
        tgt_ea_o = LS_BASE + (64'(idx) * LS_STRIDE) + 64'(off);
        if (is_put || is_get) route_o = RT_XFER;
      end else if (snr_hit) begin
        route_o = RT_SNR;
      end
    end
  end
endmodule

// File: rtl/dwr_snr_bank.sv
module dwr_snr_bank
  import dwr_pkg::*;
#(
  parameter int N_PEER = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [IDX_W-1:0]    wr_peer_i,
  input  logic                wr_sel_i,
  input  logic [31:0]         wr_data_i,
  input  logic [2*N_PEER-1:0] mode_i,
  input  logic [IDX_W-1:0]    rd_peer_i,
  input  logic                rd_sel_i,
  output logic [31:0]         rd_data_o
);
  logic [31:0] snr_q [N_PEER][2];

  for (genvar p = 0; p < N_PEER; p++) begin : g_peer
    for (genvar r = 0; r < 2; r++) begin : g_reg
      logic hit;
      assign hit = wr_i && (wr_peer_i == IDX_W'(p)) && (wr_sel_i == 1'(r));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) snr_q[p][r] <= '0;
        else if (hit) snr_q[p][r] <= mode_i[2*p+r] ? (snr_q[p][r] | wr_data_i) : wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int p = 0; p < N_PEER; p++) begin
      if (rd_peer_i == IDX_W'(p)) rd_data_o = snr_q[p][rd_sel_i];
    end
  end
endmodule

// File: rtl/dwr_issue.sv
module dwr_issue #(
  parameter int MAX_OUT = 4,
  parameter int LSA_W   = 18,
  parameter int SIZE_W  = 16,
  parameter int TAG_W   = 5,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              put_i,
  input  logic [63:0]       ea_i,
  input  logic [LSA_W-1:0]  lsa_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              ready_i,
  input  logic              cpl_i,
  output logic              valid_o,
  output logic              put_o,
  output logic [63:0]       ea_o,
  output logic [LSA_W-1:0]  lsa_o,
  output logic [SIZE_W-1:0] size_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [CNT_W-1:0]  out_cnt_o
);
  logic issue, retire;

  assign issue  = valid_o && ready_i;
  assign retire = cpl_i && (out_cnt_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      put_o   <= 1'b0;
      ea_o    <= '0;
      lsa_o   <= '0;
      size_o  <= '0;
      tag_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      put_o   <= put_i;
      ea_o    <= ea_i;
      lsa_o   <= lsa_i;
      size_o  <= size_i;
      tag_o   <= tag_i;
    end else if (issue) begin
      valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_cnt_o <= '0;
    else if (issue && !retire) out_cnt_o <= out_cnt_o + 1'b1;
    else if (retire && !issue) out_cnt_o <= out_cnt_o - 1'b1;
  end
endmodule

// File: rtl/dma_win_router.sv
module dma_win_router
  import dwr_pkg::*;
#(
  parameter int          N_PEER    = 6,
  parameter int          MAX_OUT   = 4,
  parameter int          LSA_W     = 18,
  parameter int          SIZE_W    = 16,
  parameter int          TAG_W     = 5,
  parameter logic [63:0] LS_BASE   = 64'h0000_0002_0000_0000,
  parameter logic [63:0] LS_STRIDE = 64'h0000_0000_0004_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic [7:0]          cmd_op_i,
  input  logic [TAG_W-1:0]    cmd_tag_i,
  input  logic [LSA_W-1:0]    cmd_lsa_i,
  input  logic [63:0]         cmd_ea_i,
  input  logic [SIZE_W-1:0]   cmd_size_i,
  input  logic                grp_valid_i,
  input  logic [N_PEER-1:0]   peer_present_i,
  input  logic [2*N_PEER-1:0] snr_mode_i,
  output logic [LSA_W-1:0]    ls_rd_addr_o,
  input  logic [31:0]         ls_rd_data_i,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic                req_put_o,
  output logic [63:0]         req_ea_o,
  output logic [LSA_W-1:0]    req_lsa_o,
  output logic [SIZE_W-1:0]   req_size_o,
  output logic [TAG_W-1:0]    req_tag_o,
  input  logic                cpl_i,
  output logic                sts_valid_o,
  output logic                sts_err_o,
  input  logic [7:0]          snr_rd_peer_i,
  input  logic                snr_rd_sel_i,
  output logic [31:0]         snr_rd_data_o
);
  localparam int CNT_W = $clog2(MAX_OUT + 1);

  route_e           route;
  logic             dec_put, dec_sel, accept, ordered;
  logic [63:0]      dec_ea;
  logic [IDX_W-1:0] dec_peer;
  logic [CNT_W-1:0] out_cnt;

  dwr_decode #(
    .N_PEER(N_PEER), .SIZE_W(SIZE_W), .LS_BASE(LS_BASE), .LS_STRIDE(LS_STRIDE)
  ) u_decode (
    .op_i(cmd_op_i), .ea_i(cmd_ea_i), .size_i(cmd_size_i), .grp_i(grp_valid_i),
    .present_i(peer_present_i), .route_o(route), .put_o(dec_put), .tgt_ea_o(dec_ea),
    .peer_o(dec_peer), .snr_sel_o(dec_sel)
  );

  // barrier/fence drain every outstanding transfer before entry
  assign ordered     = |(cmd_op_i[1:0]);
  assign cmd_ready_o = !req_valid_o && (out_cnt < CNT_W'(MAX_OUT)) &&
                       (!ordered || out_cnt == '0);
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign ls_rd_addr_o = cmd_lsa_i;

  dwr_issue #(
    .MAX_OUT(MAX_OUT), .LSA_W(LSA_W), .SIZE_W(SIZE_W), .TAG_W(TAG_W)
  ) u_issue (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept && route == RT_XFER),
    .put_i(dec_put), .ea_i(dec_ea), .lsa_i(cmd_lsa_i), .size_i(cmd_size_i),
    .tag_i(cmd_tag_i), .ready_i(req_ready_i), .cpl_i(cpl_i), .valid_o(req_valid_o),
    .put_o(req_put_o), .ea_o(req_ea_o), .lsa_o(req_lsa_o), .size_o(req_size_o),
    .tag_o(req_tag_o), .out_cnt_o(out_cnt)
  );

  dwr_snr_bank #(.N_PEER(N_PEER)) u_snr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(accept && route == RT_SNR),
    .wr_peer_i(dec_peer), .wr_sel_i(dec_sel), .wr_data_i(ls_rd_data_i),
    .mode_i(snr_mode_i), .rd_peer_i(snr_rd_peer_i), .rd_sel_i(snr_rd_sel_i),
    .rd_data_o(snr_rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_valid_o <= 1'b0;
      sts_err_o   <= 1'b0;
    end else begin
      sts_valid_o <= accept;
      sts_err_o   <= accept && (route == RT_ERR);
    end
  end
endmodule

// File: rtl/dwr_checker.sv
module dwr_checker #(
  parameter int MAX_OUT = 4,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_valid_i,
  input logic        cmd_ready_o,
  input logic [7:0]  cmd_op_i,
  input logic        req_valid_o,
  input logic        req_ready_i,
  input logic [63:0] req_ea_o,
  input logic        cpl_i,
  input logic        sts_valid_o,
  input logic        sts_err_o
);
  logic [CNT_W-1:0] pend;
  logic             acc, iss, ret;

  assign acc = cmd_valid_i && cmd_ready_o;
  assign iss = req_valid_o && req_ready_i;
  assign ret = cpl_i && (pend != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend <= '0;
    else if (iss && !ret) pend <= pend + 1'b1;
    else if (ret && !iss) pend <= pend - 1'b1;
  end

  AST_STS_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> sts_valid_o); // R10
  AST_STS_ONLY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_valid_o |-> $past(acc)); // R10
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_ea_o))); // R12
  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !cmd_ready_o); // R12
  AST_ORDERED_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && |cmd_op_i[1:0]) |-> (pend == '0)); // R11
  AST_ERR_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_valid_o && sts_err_o) |-> !req_valid_o); // R9
  AST_REQ_ON_SUCCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> (sts_valid_o && !sts_err_o)); // R2
endmodule

bind dma_win_router dwr_checker #(.MAX_OUT(MAX_OUT)) u_dwr_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
  .cmd_op_i(cmd_op_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
  .req_ea_o(req_ea_o), .cpl_i(cpl_i), .sts_valid_o(sts_valid_o), .sts_err_o(sts_err_o)
);

// File: tb/tb_dma_win_router.sv
`timescale 1ns/1ps
module tb_dma_win_router;
  localparam int N_PEER = 6;
  localparam int LSA_W = 18, SIZE_W = 16, TAG_W = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [7:0] cmd_op = '0;
  logic [TAG_W-1:0] cmd_tag = '0;
  logic [LSA_W-1:0] cmd_lsa = '0;
  logic [63:0] cmd_ea = '0;
  logic [SIZE_W-1:0] cmd_size = '0;
  logic grp_valid = 1'b1;
  logic [N_PEER-1:0] present = 6'b110111;
  logic [2*N_PEER-1:0] mode = 12'b0000_0000_1000;
  logic [LSA_W-1:0] ls_addr;
  logic [31:0] ls_data;
  logic req_valid, req_ready = 1'b0, req_put, cpl = 1'b0;
  logic [63:0] req_ea;
  logic [LSA_W-1:0] req_lsa;
  logic [SIZE_W-1:0] req_size;
  logic [TAG_W-1:0] req_tag;
  logic sts_valid, sts_err;
  logic [7:0] rd_peer = '0;
  logic rd_sel = 1'b0;
  logic [31:0] rd_data;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign ls_data = 32'hA500_0000 | 32'(ls_addr);

  dma_win_router dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_tag_i(cmd_tag), .cmd_lsa_i(cmd_lsa), .cmd_ea_i(cmd_ea),
    .cmd_size_i(cmd_size), .grp_valid_i(grp_valid), .peer_present_i(present),
    .snr_mode_i(mode), .ls_rd_addr_o(ls_addr), .ls_rd_data_i(ls_data),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_put_o(req_put),
    .req_ea_o(req_ea), .req_lsa_o(req_lsa), .req_size_o(req_size), .req_tag_o(req_tag),
    .cpl_i(cpl), .sts_valid_o(sts_valid), .sts_err_o(sts_err),
    .snr_rd_peer_i(rd_peer), .snr_rd_sel_i(rd_sel), .snr_rd_data_o(rd_data)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [63:0] ea;
    logic [15:0] size;
    logic [1:0]  kind;   // 0 error, 1 routed, 2 signal write
    logic        put;
    logic [63:0] xea;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{8'h20, 64'h0000_0000_1234_5670, 16'h0080, 2'd1, 1'b1, 64'h0000_0000_1234_5670}, // R2
    '{8'h40, 64'h0000_0001_0000_0100, 16'h0040, 2'd1, 1'b0, 64'h0000_0001_0000_0100}, // R2
    '{8'h24, 64'h0000_0000_0000_8000, 16'h0010, 2'd1, 1'b1, 64'h0000_0000_0000_8000}, // R1
    '{8'h42, 64'h0000_0000_0000_9000, 16'h0010, 2'd1, 1'b0, 64'h0000_0000_0000_9000}, // R1
    '{8'h60, 64'h0000_0000_0000_1000, 16'h0010, 2'd0, 1'b0, 64'h0},                    // R2
    '{8'h10, 64'h0000_0000_0000_1000, 16'h0010, 2'd0, 1'b0, 64'h0},                    // R2
    '{8'h20, 64'h0000_0000_F020_0100, 16'h0010, 2'd1, 1'b1, 64'h0000_0002_0008_0100}, // R6
    '{8'h40, 64'h0000_0000_F003_FFF0, 16'h0010, 2'd1, 1'b0, 64'h0000_0002_0003_FFF0}, // R6
    '{8'h40, 64'h0000_0000_F003_FFF0, 16'h0011, 2'd0, 1'b0, 64'h0},                    // R6
    '{8'h20, 64'hABCD_0000_F010_0000, 16'h0004, 2'd1, 1'b1, 64'h0000_0002_0004_0000}, // R3
    '{8'h20, 64'h0000_0000_F030_0000, 16'h0004, 2'd0, 1'b0, 64'h0},                    // R5
    '{8'h20, 64'h0000_0000_F060_0000, 16'h0004, 2'd0, 1'b0, 64'h0},                    // R5
    '{8'h40, 64'h0000_0000_F005_400C, 16'h0004, 2'd0, 1'b0, 64'h0},                    // R9
    '{8'h20, 64'h0000_0000_F005_400C, 16'h0008, 2'd0, 1'b0, 64'h0},                    // R9
    '{8'h20, 64'h0000_0000_F006_0000, 16'h0004, 2'd0, 1'b0, 64'h0},                    // R9
    '{8'h20, 64'h0000_0000_E010_0000, 16'h0004, 2'd1, 1'b1, 64'h0000_0000_E010_0000}, // R3
    '{8'h30, 64'h0000_0000_F010_0000, 16'h0004, 2'd0, 1'b0, 64'h0},                    // R9
    '{8'h20, 64'h0000_0000_F005_C00C, 16'h0004, 2'd2, 1'b0, 64'h0}                     // R7
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // present at negedge, accept at posedge, sample status at following negedge
  task automatic run_cmd(input logic [7:0] op, input logic [63:0] ea, input logic [15:0] sz,
                         input logic [17:0] lsa, output logic err, output logic rv,
                         output logic put, output logic [63:0] rea);
    @(negedge clk);
    cmd_op = op; cmd_ea = ea; cmd_size = sz; cmd_lsa = lsa; cmd_tag = 5'd3; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 status one cycle after accept", 64'(sts_valid), 64'd1);
    err = sts_err; rv = req_valid; put = req_put; rea = req_ea;
    if (rv) begin
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0; cpl = 1'b1;
      @(negedge clk);
      cpl = 1'b0;
    end
  endtask

  task automatic rd_snr(input int p, input logic s, output logic [31:0] v);
    @(negedge clk);
    rd_peer = 8'(p); rd_sel = s;
    #1 v = rd_data;
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    logic e, rv, pt;
    logic [63:0] ea;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 no request after reset", 64'(req_valid), 64'd0);
    chk("R13 no status after reset", 64'(sts_valid), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R13 ready after reset", 64'(cmd_ready), 64'd1);
    for (int p = 0; p < N_PEER; p++) begin
      for (int s = 0; s < 2; s++) begin
        rd_snr(p, 1'(s), v);
        chk("R13 signal register zero", 64'(v), 64'd0);
      end
    end

    for (int i = 0; i < NV; i++) begin
      run_cmd(VECS[i].op, VECS[i].ea, VECS[i].size, 18'h100, e, rv, pt, ea);
      chk($sformatf("R1/R2/R3/R5/R6/R7/R9 vec %0d err", i), 64'(e), 64'(VECS[i].kind == 2'd0));
      chk($sformatf("R1/R2/R3/R6/R7/R9 vec %0d request", i), 64'(rv), 64'(VECS[i].kind == 2'd1));
      if (VECS[i].kind == 2'd1) begin
        chk($sformatf("R2/R6 vec %0d direction", i), 64'(pt), 64'(VECS[i].put));
        chk($sformatf("R2/R6 vec %0d address", i), ea, VECS[i].xea);
      end
    end
    rd_snr(0, 1'b1, v);
    chk("R7 peer0 reg2 from table write", 64'(v), 64'hA500_0100);

    // R7/R8 peer0 reg1 overwrite mode (mode bit 0 clear)
    run_cmd(8'h20, 64'hF005_400C, 16'd4, 18'h0F0, e, rv, pt, ea);
    run_cmd(8'h20, 64'hF005_400C, 16'd4, 18'h00F, e, rv, pt, ea);
    chk("R7 signal write success", 64'(e), 64'd0);
    chk("R7 signal write no request", 64'(rv), 64'd0);
    rd_snr(0, 1'b0, v);
    chk("R8 peer0 reg1 overwrite", 64'(v), 64'hA500_000F);
    rd_snr(0, 1'b1, v);
    chk("R7 peer0 reg2 untouched", 64'(v), 64'hA500_0100);
    // R8 peer1: bit2 clear (reg1 overwrite), bit3 set (reg2 OR)
    run_cmd(8'h20, 64'hF015_C00C, 16'd4, 18'h0F0, e, rv, pt, ea);
    run_cmd(8'h20, 64'hF015_C00C, 16'd4, 18'h00F, e, rv, pt, ea);
    run_cmd(8'h21, 64'hF015_400C, 16'd4, 18'h0A0, e, rv, pt, ea);
    run_cmd(8'h20, 64'hF015_400C, 16'd4, 18'h050, e, rv, pt, ea);
    rd_snr(1, 1'b1, v);
    chk("R8 peer1 reg2 OR accumulate", 64'(v), 64'hA500_00FF);
    rd_snr(1, 1'b0, v);
    chk("R8 peer1 reg1 overwrite", 64'(v), 64'hA500_0050);

    // R4 no group association
    grp_valid = 1'b0;
    run_cmd(8'h20, 64'hF020_0100, 16'h10, 18'h100, e, rv, pt, ea);
    chk("R4 no group window error", 64'(e), 64'd1);
    chk("R4 no group no request", 64'(rv), 64'd0);
    run_cmd(8'h20, 64'h0000_2000, 16'h10, 18'h100, e, rv, pt, ea);
    chk("R4 no group outside window ok", 64'(e), 64'd0);
    grp_valid = 1'b1;

    // R10 status is a single-cycle pulse
    @(negedge clk);
    chk("R10 status dropped", 64'(sts_valid), 64'd0);

    // R12 request held while data mover stalls
    @(negedge clk);
    cmd_op = 8'h40; cmd_ea = 64'h0000_7000; cmd_size = 16'h20; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 8'h20; cmd_ea = 64'h0000_7100;
    repeat (3) @(negedge clk);
    chk("R12 request held", 64'(req_valid), 64'd1);
    chk("R12 request address stable", req_ea, 64'h0000_7000);
    chk("R12 no accept while pending", 64'(cmd_ready), 64'd0);
    cmd_valid = 1'b0;
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk("R12 request released", 64'(req_valid), 64'd0);

    // R11 one request outstanding (no completion yet)
    cmd_op = 8'h21; cmd_ea = 64'h0000_7200; cmd_valid = 1'b1;
    @(negedge clk);
    chk("R11 barrier held off", 64'(cmd_ready), 64'd0);
    cmd_op = 8'h22;
    @(negedge clk);
    chk("R11 fence held off", 64'(cmd_ready), 64'd0);
    cmd_valid = 1'b0;
    cmd_op = 8'h24;
    #1 chk("R11 list bit not held", 64'(cmd_ready), 64'd1);
    cpl = 1'b1;
    @(negedge clk);
    cpl = 1'b0;
    cmd_op = 8'h21;
    #1 chk("R11 barrier free after completion", 64'(cmd_ready), 64'd1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule